// File: doc/BRIEF.md
# Interrupt Mask Controller with Set/Clear Shortcuts

This block gathers 64 interrupt sources, merges each raw input with a software force bit, gates the result through a 64-bit mask and raises one request line whenever anything survives the mask. The lowest-numbered surviving source is the active one. Software reads an acknowledge register to learn its vector. The mask and force registers are 64 bits wide and are reached as two 32-bit halves over a plain read/write register bus addressed in bytes.

Two byte-wide command offsets change the mask without a read-modify-write. One sets mask bits and the other clears them. Each command either acts on the single bit named by the low six data bits or, when its "all" flag is set, on all 64 bits at once. The whole update happens in one write, so a second agent sharing the mask cannot lose a change between a read and a write-back.

The bus is a plain single-cycle request: every request with `bus_req` high gets a response one clock later on `rsp_valid`, carrying the read data and an error flag. The bus has no back-pressure; the controller accepts a request in every cycle.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset every mask bit is 1, every force bit is 0 and `irq_req` is 0.
- R2: Offset 0x08 reads and writes mask bits 63:32 and offset 0x0C reads and writes mask bits 31:0. A write to one half leaves the other half unchanged.
- R3: Offset 0x10 reads and writes force bits 63:32 and offset 0x14 reads and writes force bits 31:0. A write to one half leaves the other half unchanged.
- R4: A write to offset 0x1C with data bit 6 set makes all 64 mask bits 1.
- R5: A write to offset 0x1C with data bit 6 clear sets only the mask bit whose index is data bits 5:0, for any index 0 to 63. Data bit 7 is ignored.
- R6: A write to offset 0x1D with data bit 6 set makes all 64 mask bits 0.
- R7: A write to offset 0x1D with data bit 6 clear clears only the mask bit whose index is data bits 5:0.
- R8: A read of offset 0x1C or 0x1D returns zero with no error.
- R9: Source i is pending when (`src[i]` or force bit i) is 1 and mask bit i is 0. `irq_req` is 1 in the same cycle exactly when at least one source is pending.
- R10: A read of offset 0xE0 returns 64 plus the number of the lowest pending source, sampled in the request cycle.
- R11: A read of offset 0xE0 returns 0x18 when no source is pending.
- R12: An access to any other offset, and a write to 0xE0, responds with `rsp_err` = 1 and read data 0, and changes no register.
- R13: `rsp_valid` is 1 in the cycle after each cycle with `bus_req` = 1 and 0 otherwise. `rsp_rdata` and `rsp_err` are valid only while `rsp_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src | input | 64 | Raw interrupt source levels |
| bus_req | input | 1 | Access request, one per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data; commands use bits 6:0 |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Undecoded offset or illegal write |
| irq_req | output | 1 | Any source pending |

## Verification
The bench aims set and clear commands at indices 32 to 63. A design that builds the bit from a 32-bit shift would then miss the upper mask half or hit a wrong bit. It issues commands with the all flag and junk in bit 7 to catch a decoder that reads the wrong data bit. It checks each half-write against the untouched half to expose a write that clobbers both. For the acknowledge read, it places several pending sources at once, some from force bits only and some hidden behind the mask. This exposes a picker that favours the highest source or ignores force. An empty pending set must return the spurious vector. Undecoded offsets must answer with an error and leave the mask unchanged.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_MASK_HI  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_MASK_LO  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_FORCE_HI = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_FORCE_LO = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_CMD_SET  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_CMD_CLR  = 8'h1D;
  localparam logic [ADDR_W-1:0] OFS_ACK      = 8'hE0;

  localparam int unsigned CMD_ALL_BIT = 6;

  typedef struct packed {
    logic mask_hi;
    logic mask_lo;
    logic force_hi;
    logic force_lo;
    logic cmd_set;
    logic cmd_clr;
  } wr_sel_t;
endpackage

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
  import irq_mask_pkg::*;
#(
  parameter int unsigned NSRC = 64,
  localparam int unsigned HALF = NSRC / 2,
  localparam int unsigned IDXW = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wr_sel_t           wsel,
  input  logic [DATA_W-1:0] wdata,
  output logic [NSRC-1:0]   mask_o,
  output logic [NSRC-1:0]   force_o
);
  logic            cmd_all;
  logic [IDXW-1:0] cmd_idx;

  assign cmd_all = wdata[CMD_ALL_BIT];
  assign cmd_idx = wdata[IDXW-1:0];

  // One flop per bit: the command index is compared against the bit's own
  // number, so no shifter of any width is needed.
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    logic hit;
    logic wr_m;
    logic wr_f;
    logic wbit;
    assign hit = cmd_all || (cmd_idx == IDXW'(i));
    if (i >= HALF) begin : g_hi
      assign wr_m = wsel.mask_hi;
      assign wr_f = wsel.force_hi;
      assign wbit = wdata[i-HALF];
    end else begin : g_lo
      assign wr_m = wsel.mask_lo;
      assign wr_f = wsel.force_lo;
      assign wbit = wdata[i];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask_o[i]  <= 1'b1;
        force_o[i] <= 1'b0;
      end else begin
        if (wsel.cmd_set && hit)      mask_o[i] <= 1'b1;
        else if (wsel.cmd_clr && hit) mask_o[i] <= 1'b0;
        else if (wr_m)                mask_o[i] <= wbit;
        if (wr_f)                     force_o[i] <= wbit;
      end
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned NSRC = 64,
  localparam int unsigned IDXW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] pend,
  output logic            any_o,
  output logic [IDXW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        any_o = 1'b1;
        idx_o = IDXW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irq_mask_pkg::*;
#(
  parameter int unsigned NSRC     = 64,
  parameter int unsigned VEC_BASE = 64,
  parameter int unsigned SPUR_VEC = 8'h18,
  localparam int unsigned HALF = NSRC / 2,
  localparam int unsigned IDXW = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              irq_req
);
  logic [NSRC-1:0]   mask_q;
  logic [NSRC-1:0]   force_q;
  logic [NSRC-1:0]   pend;
  logic              any_pend;
  logic [IDXW-1:0]   act_idx;
  wr_sel_t           wsel;
  logic [DATA_W-1:0] rd_data;
  logic              dec_err;

  always_comb begin
    wsel    = '0;
    rd_data = '0;
    dec_err = 1'b0;
    unique case (bus_addr)
      OFS_MASK_HI:  begin wsel.mask_hi  = bus_we; rd_data = mask_q[NSRC-1:HALF];  end
      OFS_MASK_LO:  begin wsel.mask_lo  = bus_we; rd_data = mask_q[HALF-1:0];     end
      OFS_FORCE_HI: begin wsel.force_hi = bus_we; rd_data = force_q[NSRC-1:HALF]; end
      OFS_FORCE_LO: begin wsel.force_lo = bus_we; rd_data = force_q[HALF-1:0];    end
      OFS_CMD_SET:  wsel.cmd_set = bus_we;
      OFS_CMD_CLR:  wsel.cmd_clr = bus_we;
      OFS_ACK: begin
        dec_err = bus_we;
        if (!bus_we)
          rd_data = any_pend ? DATA_W'(VEC_BASE) + DATA_W'(act_idx) : DATA_W'(SPUR_VEC);
      end
      default: dec_err = 1'b1;
    endcase
    if (!bus_req) wsel = '0;
    if (!bus_we)  wsel = '0;
  end

  irq_mask_regs #(.NSRC(NSRC)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wsel   (wsel),
    .wdata  (bus_wdata),
    .mask_o (mask_q),
    .force_o(force_q)
  );

  assign pend = (src | force_q) & ~mask_q;

  irq_pick #(.NSRC(NSRC)) u_pick (
    .pend (pend),
    .any_o(any_pend),
    .idx_o(act_idx)
  );

  assign irq_req = any_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= bus_req;
      rsp_rdata <= (bus_req && !bus_we) ? rd_data : '0;
      rsp_err   <= bus_req && dec_err;
    end
  end
endmodule

// File: rtl/irq_mask_ctrl_chk.sv
module irq_mask_ctrl_chk
  import irq_mask_pkg::*;
#(
  parameter int unsigned NSRC = 64,
  localparam int unsigned HALF = NSRC / 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_err,
  input logic              irq_req,
  input logic [NSRC-1:0]   mask_q
);
  logic wr_set, wr_clr, rd_cmd, rd_ack, wr_mhi, known;

  assign wr_set = bus_req && bus_we && bus_addr == OFS_CMD_SET;
  assign wr_clr = bus_req && bus_we && bus_addr == OFS_CMD_CLR;
  assign wr_mhi = bus_req && bus_we && bus_addr == OFS_MASK_HI;
  assign rd_cmd = bus_req && !bus_we && (bus_addr == OFS_CMD_SET || bus_addr == OFS_CMD_CLR);
  assign rd_ack = bus_req && !bus_we && bus_addr == OFS_ACK;
  assign known  = bus_addr inside {OFS_MASK_HI, OFS_MASK_LO, OFS_FORCE_HI, OFS_FORCE_LO,
                                   OFS_CMD_SET, OFS_CMD_CLR, OFS_ACK};

  assert_set_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set && bus_wdata[CMD_ALL_BIT] |=> mask_q == '1);

  assert_set_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set && !bus_wdata[CMD_ALL_BIT] |=> mask_q[$past(bus_wdata[5:0])]);

  assert_clr_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr && bus_wdata[CMD_ALL_BIT] |=> mask_q == '0);

  assert_clr_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr && !bus_wdata[CMD_ALL_BIT] |=> !mask_q[$past(bus_wdata[5:0])]);

  assert_half_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mhi |=> mask_q[HALF-1:0] == $past(mask_q[HALF-1:0]));

  assert_cmd_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd |=> rsp_rdata == '0 && !rsp_err);

  assert_spurious_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack && !irq_req |=> rsp_rdata == DATA_W'(8'h18));

  assert_bad_offset_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !known |=> rsp_err && rsp_rdata == '0);

  assert_bad_keeps_mask_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !known |=> $stable(mask_q));

  assert_rsp_follows_R13: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> rsp_valid);

  assert_rsp_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> !rsp_valid);
endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk #(.NSRC(NSRC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_req  (bus_req),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata),
  .rsp_err  (rsp_err),
  .irq_req  (irq_req),
  .mask_q   (mask_q)
);

// File: tb/tb_irq_mask_ctrl.sv
module tb_irq_mask_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic        irq_req;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] m_mask;
  logic [63:0] m_force;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  irq_mask_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src(src),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .irq_req(irq_req)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_ack(input logic [63:0] s, input logic [63:0] f,
                                          input logic [63:0] m);
    logic [63:0] p;
    p = (s | f) & ~m;
    for (int i = 0; i < 64; i++)
      if (p[i]) return 32'(64 + i);
    return 32'h18;
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h08: return m_mask[63:32];
      8'h0C: return m_mask[31:0];
      8'h10: return m_force[63:32];
      8'h14: return m_force[31:0];
      8'hE0: return exp_ack(src, m_force, m_mask);
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic exp_err(input logic we, input logic [7:0] a);
    if (a inside {8'h08, 8'h0C, 8'h10, 8'h14, 8'h1C, 8'h1D}) return 1'b0;
    if (a == 8'hE0) return we;
    return 1'b1;
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    case (a)
      8'h08: m_mask[63:32]  = d;
      8'h0C: m_mask[31:0]   = d;
      8'h10: m_force[63:32] = d;
      8'h14: m_force[31:0]  = d;
      8'h1C: if (d[6]) m_mask = '1; else m_mask[d[5:0]] = 1'b1;
      8'h1D: if (d[6]) m_mask = '0; else m_mask[d[5:0]] = 1'b0;
      default: ;
    endcase
  endtask

  // Drive at negedge, register at posedge, sample at the following negedge.
  task automatic access(input logic we, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic er, output logic vl);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    rd = rsp_rdata; er = rsp_err; vl = rsp_valid;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
    logic [31:0] rd; logic er; logic vl;
    access(1'b1, a, d, rd, er, vl);
    check({req, " write err"}, 64'(er), 64'(exp_err(1'b1, a)));
    if (!exp_err(1'b1, a)) model_write(a, d);
  endtask

  task automatic rd_chk(input logic [7:0] a, input string req);
    logic [31:0] exp; logic [31:0] rd; logic er; logic vl;
    exp = exp_read(a);
    access(1'b0, a, 32'h0, rd, er, vl);
    check({req, " rdata"}, 64'(rd), 64'(exp));
    check({req, " err"}, 64'(er), 64'(exp_err(1'b0, a)));
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd; logic er; logic vl;
    void'($urandom(32'd1234));
    m_mask = '1; m_force = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R9 masked sources give no request
    rd_chk(8'h08, "R1");
    rd_chk(8'h0C, "R1");
    rd_chk(8'h10, "R1");
    rd_chk(8'h14, "R1");
    check("R1 irq", 64'(irq_req), 64'h0);
    src = '1; #1;
    check("R9 masked irq", 64'(irq_req), 64'h0);
    rd_chk(8'hE0, "R11 spurious all masked");
    src = '0;

    // R13 response timing
    access(1'b0, 8'h08, 32'h0, rd, er, vl);
    check("R13 valid after req", 64'(vl), 64'h1);
    @(negedge clk);
    check("R13 idle", 64'(rsp_valid), 64'h0);

    // R6 / R5 / R7 / R4 commands, bit 7 junk
    wr(8'h1D, 32'hC0, "R6"); rd_chk(8'h08, "R6"); rd_chk(8'h0C, "R6");
    wr(8'h1C, 32'h80 | 40, "R5"); rd_chk(8'h08, "R5 upper idx 40");
    rd_chk(8'h0C, "R5 lower untouched");
    wr(8'h1C, 32'd63, "R5"); wr(8'h1C, 32'd3, "R5");
    rd_chk(8'h08, "R5 idx 63"); rd_chk(8'h0C, "R5 idx 3");
    wr(8'h1D, 32'd40, "R7"); rd_chk(8'h08, "R7 clear 40");
    wr(8'h1C, 32'h40, "R4"); rd_chk(8'h08, "R4"); rd_chk(8'h0C, "R4");
    rd_chk(8'h1C, "R8"); rd_chk(8'h1D, "R8");

    // R2 / R3 half writes
    wr(8'h08, 32'h1234_5678, "R2"); rd_chk(8'h0C, "R2 lo kept"); rd_chk(8'h08, "R2 hi");
    wr(8'h14, 32'hA5A5_0F0F, "R3"); rd_chk(8'h10, "R3 hi kept"); rd_chk(8'h14, "R3 lo");

    // R9 / R10 priority with force and masked lower source
    wr(8'h1D, 32'h40, "R6");
    wr(8'h14, 32'h0000_0220, "R3"); wr(8'h10, 32'h0, "R3");
    wr(8'h1C, 32'd5, "R5");
    src = 64'h0000_0001_0000_0008; #1;
    check("R9 irq force", 64'(irq_req), 64'h1);
    rd_chk(8'hE0, "R10 lowest");
    src = '0; wr(8'h14, 32'h0, "R3"); wr(8'h08, 32'h0, "R2");
    src = 64'h8000_0000_0000_0000; #1;
    rd_chk(8'hE0, "R10 idx 63");
    src = '0; #1;
    check("R9 none", 64'(irq_req), 64'h0);
    rd_chk(8'hE0, "R11 empty");

    // R12 undecoded and illegal accesses
    rd_chk(8'h20, "R12"); rd_chk(8'h04, "R12");
    wr(8'h0D, 32'hFFFF_FFFF, "R12"); wr(8'hE0, 32'h0, "R12");
    rd_chk(8'h0C, "R12 mask kept");

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [7:0] a; logic [31:0] d; int op;
      src = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      op = $urandom_range(0, 9);
      case (op)
        0: a = 8'h08; 1: a = 8'h0C; 2: a = 8'h10; 3: a = 8'h14;
        4: a = 8'h1C; 5: a = 8'h1D; 6: a = 8'hE0; 7: a = 8'hE0;
        8: a = 8'h1C; default: a = 8'(($urandom_range(0, 63)) * 4);
      endcase
      d = $urandom;
      if (a == 8'h1C || a == 8'h1D) d = ($urandom_range(0, 7) == 0) ? (d | 32'h40) : (d & ~32'h40);
      if ($urandom_range(0, 1) == 1 && a != 8'hE0) wr(a, d, "R2 R3 R4 R5 R6 R7 R12 rand");
      else rd_chk(a, "R8 R10 R11 R12 rand");
      #1;
      check("R9 rand irq", 64'(irq_req),
            64'(((src | m_force) & ~m_mask) != 0));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule